// File: doc/BRIEF.md
# Oversampling Serial Receive Recovery

This block is the input end of an asynchronous serial receiver. The receive line is first passed through a two-flop synchronizer. It is then sampled on a clock enable that runs at sixteen times the bit rate. The block hunts for the falling edge that marks a start bit. Once it finds one, it takes three samples near the centre of every bit and decides the bit value by majority vote. A bit whose three samples do not all agree is counted as noisy.

Each voted bit is presented on a one-cycle strobe to a bit-rate deserializer inside the block. The deserializer checks the start bit and collects 8 or 9 data bits, least significant first. It then judges the stop bit. At the end of a frame it presents the received word with a one-cycle valid pulse, together with a framing-error flag and a noise flag. The word and both flags hold until the next frame ends. The 16x enable comes from an external baud generator.

Top module: `uart_rx_recovery`

## Requirements
- R1: After reset the block hunts for a start edge, and word_o, word_valid_o, frame_err_o, noise_o, bit_o and bit_strobe_o are all 0.
- R2: A frame starts on a 1-to-0 change of the synchronized line, seen between two 16x ticks. With tick16_i high every cycle, word_valid_o rises 158 cycles after the first low sample for an 8-bit frame. For a 9-bit frame it rises 174 cycles after the first low sample.
- R3: Each bit value is the majority of the samples taken at 16x phases 8, 9 and 10 of that bit, where phase 0 of the start bit is its first low sample. Samples at other phases have no effect on the word.
- R4: noise_o is set for a frame when the three samples of any of its bits disagree. It is cleared by the next frame whose bits are all unanimous.
- R5: If the start bit votes 1, the event is a false start. No word is delivered, and the block resumes hunting for a start edge.
- R6: A stop bit that votes 0 sets frame_err_o. The word is still delivered with word_valid_o.
- R7: When nine_bit_i is 0, a frame has 8 data bits in word_o[7:0] and word_o[8] reads 0. When nine_bit_i is 1, a frame has 9 data bits. Bits arrive LSB first. The mode must be held stable during a frame.
- R8: bit_strobe_o pulses for one cycle for every voted bit, including the start bit and the stop bit. bit_o carries the voted value during that pulse, so an 8-bit frame gives 10 strobes.
- R9: The sampling state advances only on cycles where tick16_i is high. A frame sent with a tick every other cycle decodes to the same word.
- R10: word_valid_o is a one-cycle pulse. word_o, frame_err_o and noise_o change only with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial receive line |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit_o | output | 1 | Voted value of the latest bit |
| bit_strobe_o | output | 1 | One-cycle pulse per voted bit |
| word_o | output | 9 | Last received word |
| word_valid_o | output | 1 | One-cycle pulse when a frame ends |
| frame_err_o | output | 1 | Stop bit of the last frame voted 0 |
| noise_o | output | 1 | A bit of the last frame had disagreeing samples |

## Verification
With the enable high every cycle, there are two register stages of synchronizer and one stage of edge detection. The third vote sample then lands ten ticks into each bit. bit_strobe_o therefore appears one cycle after that sample, and word_valid_o one cycle after the stop-bit strobe. That gives 158 cycles from the first low sample for 8 data bits and 174 for 9. A monitor samples the ports on the falling clock edge and records the cycle number of each valid pulse. Latencies are then compared exactly against those figures. The word, the flags and the strobe count are checked once the frame and some idle time have passed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rxr_sync.sv
module rxr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle line level
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxr_sampler.sv
module rxr_sampler
  import rxr_pkg::*;
#(
  parameter int unsigned OSR = 16  // power of two
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic at_start_i,
  input  logic at_stop_i,
  output logic bit_o,
  output logic strobe_o,
  output logic noisy_o
);
  localparam int unsigned PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_A = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0] PH_B = PH_W'(OSR / 2 + 1);
  localparam logic [PH_W-1:0] PH_C = PH_W'(OSR / 2 + 2);

  rx_state_e       state_q;
  logic [PH_W-1:0] phase_q;
  logic            rx_q, smp_a_q, smp_b_q;
  logic            vote;

  assign vote = (smp_a_q & smp_b_q) | (smp_a_q & rx_i) | (smp_b_q & rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      phase_q  <= '0;
      rx_q     <= 1'b1;
      smp_a_q  <= 1'b0;
      smp_b_q  <= 1'b0;
      bit_o    <= 1'b0;
      strobe_o <= 1'b0;
      noisy_o  <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (tick_i) begin
        rx_q <= rx_i;
        unique case (state_q)
          ST_HUNT: begin
            if (rx_q && !rx_i) begin
              state_q <= ST_FRAME;
              phase_q <= PH_W'(1);  // this tick is phase 0
            end
          end
          ST_FRAME: begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == PH_A) smp_a_q <= rx_i;
            if (phase_q == PH_B) smp_b_q <= rx_i;
            if (phase_q == PH_C) begin
              bit_o    <= vote;
              strobe_o <= 1'b1;
              noisy_o  <= !((smp_a_q == smp_b_q) && (smp_b_q == rx_i));
              if (at_stop_i || (at_start_i && vote)) state_q <= ST_HUNT;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  p_strobe_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(phase_q) && $stable(state_q)));
  p_strobe_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(tick_i));
endmodule

// File: rtl/rxr_deser.sv
module rxr_deser #(
  parameter int unsigned MAX_DATA = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nine_bit_i,
  input  logic                bit_i,
  input  logic                strobe_i,
  input  logic                noisy_i,
  output logic                at_start_o,
  output logic                at_stop_o,
  output logic [MAX_DATA-1:0] word_o,
  output logic                valid_o,
  output logic                ferr_o,
  output logic                noise_o
);
  localparam int unsigned IDX_W = $clog2(MAX_DATA + 2);
  localparam logic [IDX_W-1:0] STOP_LONG  = IDX_W'(MAX_DATA + 1);
  localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(MAX_DATA);

  logic [IDX_W-1:0]    idx_q;
  logic [MAX_DATA-1:0] shreg_q;
  logic                acc_q;

  // index 0 = start, 1..N = data, N+1 = stop
  assign at_start_o = (idx_q == '0);
  assign at_stop_o  = (idx_q == (nine_bit_i ? STOP_LONG : STOP_SHORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      shreg_q <= '0;
      acc_q   <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (strobe_i) begin
        if (at_start_o) begin
          if (!bit_i) begin
            idx_q <= IDX_W'(1);
            acc_q <= noisy_i;
          end
        end else if (at_stop_o) begin
          valid_o <= 1'b1;
          ferr_o  <= !bit_i;
          noise_o <= acc_q | noisy_i;
          word_o  <= nine_bit_i ? shreg_q : {1'b0, shreg_q[MAX_DATA-1:1]};
          idx_q   <= '0;
        end else begin
          shreg_q <= {bit_i, shreg_q[MAX_DATA-1:1]};
          acc_q   <= acc_q | noisy_i;
          idx_q   <= idx_q + 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_after_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe_i));
  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(word_o) && $stable(ferr_o) && $stable(noise_o)));
  p_short_top_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nine_bit_i) |-> !word_o[MAX_DATA-1]);
endmodule

// File: rtl/uart_rx_recovery.sv
module uart_rx_recovery #(
  parameter int unsigned OSR       = 16,
  parameter int unsigned MAX_DATA  = 9,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick16_i,
  input  logic                rxd_i,
  input  logic                nine_bit_i,
  output logic                bit_o,
  output logic                bit_strobe_o,
  output logic [MAX_DATA-1:0] word_o,
  output logic                word_valid_o,
  output logic                frame_err_o,
  output logic                noise_o
);
  logic rx_s, at_start, at_stop, bit_noisy;

  rxr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rxr_sampler #(.OSR(OSR)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .rx_i      (rx_s),
    .at_start_i(at_start),
    .at_stop_i (at_stop),
    .bit_o     (bit_o),
    .strobe_o  (bit_strobe_o),
    .noisy_o   (bit_noisy)
  );

  rxr_deser #(.MAX_DATA(MAX_DATA)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nine_bit_i(nine_bit_i),
    .bit_i     (bit_o),
    .strobe_i  (bit_strobe_o),
    .noisy_i   (bit_noisy),
    .at_start_o(at_start),
    .at_stop_o (at_stop),
    .word_o    (word_o),
    .valid_o   (word_valid_o),
    .ferr_o    (frame_err_o),
    .noise_o   (noise_o)
  );
endmodule

// File: tb/uart_rx_recovery_bench.sv
module uart_rx_recovery_bench;
  logic       clk = 1'b0;
  logic       rst_ni, tick16, rxd, nine_bit;
  logic       bit_o, bit_strobe, word_valid, frame_err, noise;
  logic [8:0] word;

  int n_chk = 0, n_fail = 0;
  int tdiv = 1, dcnt = 0;
  int cyc = 0, t_start = 0;
  int n_valid = 0, n_strobe = 0, cap_cyc = 0;
  logic [8:0] cap_word;
  logic cap_ferr, cap_noise, last_bit;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_recovery u_uart_rx_recovery (
    .clk_i(clk), .rst_ni(rst_ni), .tick16_i(tick16), .rxd_i(rxd),
    .nine_bit_i(nine_bit), .bit_o(bit_o), .bit_strobe_o(bit_strobe),
    .word_o(word), .word_valid_o(word_valid), .frame_err_o(frame_err),
    .noise_o(noise)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (dcnt >= tdiv - 1) begin tick16 <= 1'b1; dcnt <= 0; end
    else begin tick16 <= 1'b0; dcnt <= dcnt + 1; end
  end

  always @(negedge clk) if (rst_ni) begin
    if (word_valid) begin
      n_valid++; cap_word = word; cap_ferr = frame_err;
      cap_noise = noise; cap_cyc = cyc;
    end
    if (bit_strobe) begin n_strobe++; last_bit = bit_o; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // gbit/gph/glen: invert samples gph..gph+glen-1 of frame bit gbit
  task automatic send_frame(input logic [8:0] data, input logic nine_m, input logic stop_v,
                            input int gbit, input int gph, input int glen, input int tail);
    int nb;
    logic bv;
    nb = nine_m ? 9 : 8;
    nine_bit = nine_m;
    for (int b = 0; b < nb + 2; b++) begin
      bv = (b == 0) ? 1'b0 : (b <= nb) ? data[b-1] : stop_v;
      for (int p = 0; p < 16; p++) begin
        rxd = (b == gbit && p >= gph && p < gph + glen) ? ~bv : bv;
        if (b == 0 && p == 0) t_start = cyc;
        repeat (tdiv) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (tail * tdiv) @(negedge clk);
  endtask

  task automatic clr();
    n_valid = 0; n_strobe = 0;
  endtask

  task automatic t_reset();
    chk("R1 word", word, 9'h0);
    chk("R1 valid", word_valid, 0);
    chk("R1 ferr", frame_err, 0);
    chk("R1 noise", noise, 0);
    chk("R1 strobe", bit_strobe, 0);
    chk("R1 bit", bit_o, 0);
  endtask

  task automatic t_basic8();
    clr();
    send_frame(9'h1A5, 1'b0, 1'b1, -1, 0, 0, 24);
    chk("R7 word 8-bit", cap_word, 9'h0A5);
    chk("R10 one valid", n_valid, 1);
    chk("R6 no ferr", cap_ferr, 0);
    chk("R4 no noise", cap_noise, 0);
    chk("R2 latency 8", cap_cyc - t_start, 158);
    chk("R8 strobes", n_strobe, 10);
    chk("R8 stop bit", last_bit, 1);
  endtask

  task automatic t_nine();
    clr();
    send_frame(9'h1C3, 1'b1, 1'b1, -1, 0, 0, 24);
    chk("R7 word 9-bit", cap_word, 9'h1C3);
    chk("R2 latency 9", cap_cyc - t_start, 174);
    chk("R8 strobes 9", n_strobe, 11);
  endtask

  task automatic t_noise();
    clr();
    send_frame(9'h03C, 1'b0, 1'b1, 4, 9, 1, 24);
    chk("R3 single glitch word", cap_word, 9'h03C);
    chk("R4 single glitch noise", cap_noise, 1);
    send_frame(9'h03C, 1'b0, 1'b1, 4, 2, 4, 24);
    chk("R3 outside window word", cap_word, 9'h03C);
    chk("R3 outside window noise", cap_noise, 0);
    send_frame(9'h03C, 1'b0, 1'b1, 2, 8, 2, 24);
    chk("R3 two samples flip", cap_word, 9'h03E);
    chk("R4 two samples noise", cap_noise, 1);
    send_frame(9'h081, 1'b0, 1'b1, 6, 11, 5, 24);
    chk("R4 noise cleared", cap_noise, 0);
    chk("R3 late samples word", cap_word, 9'h081);
  endtask

  task automatic t_ferr();
    clr();
    send_frame(9'h055, 1'b0, 1'b0, -1, 0, 0, 24);
    chk("R6 ferr set", cap_ferr, 1);
    chk("R6 word delivered", cap_word, 9'h055);
    chk("R6 valid count", n_valid, 1);
    send_frame(9'h0AA, 1'b0, 1'b1, -1, 0, 0, 24);
    chk("R6 ferr clear", cap_ferr, 0);
  endtask

  task automatic t_false();
    clr();
    rxd = 1'b0; repeat (6) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    chk("R5 no word", n_valid, 0);
    chk("R5 start strobe only", n_strobe, 1);
    chk("R5 start voted 1", last_bit, 1);
    chk("R5 word untouched", word, 9'h0AA);
    send_frame(9'h096, 1'b0, 1'b1, -1, 0, 0, 24);
    chk("R5 hunt resumed", cap_word, 9'h096);
    chk("R5 latency after false start", cap_cyc - t_start, 158);
  endtask

  task automatic t_hold();
    repeat (50) @(negedge clk);
    chk("R10 word held", word, 9'h096);
    chk("R10 valid low", word_valid, 0);
  endtask

  task automatic t_b2b();
    clr();
    send_frame(9'h012, 1'b0, 1'b1, -1, 0, 0, 0);
    send_frame(9'h0ED, 1'b0, 1'b1, -1, 0, 0, 24);
    chk("R2 back-to-back count", n_valid, 2);
    chk("R2 back-to-back word", cap_word, 9'h0ED);
  endtask

  task automatic t_tick();
    clr();
    tdiv = 2;
    repeat (4) @(negedge clk);
    send_frame(9'h0F0, 1'b1, 1'b1, -1, 0, 0, 24);
    chk("R9 slow tick word", cap_word, 9'h0F0);
    chk("R9 slow tick valid", n_valid, 1);
    chk("R9 slow tick strobes", n_strobe, 11);
    tdiv = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_ni = 1'b0; rxd = 1'b1; nine_bit = 1'b0; tick16 = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_noise();
    t_ferr();
    t_false();
    t_hold();
    t_b2b();
    t_tick();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule